// File: doc/BRIEF.md
# Colour Key Match Generator

This block decides, pixel by pixel, whether the video switch downstream should take its sample from the external composite source instead of the encoded path. It watches the three values that enter the colour lookup tables (channels D, E and F) and compares each with a programmable key value. What the three values mean depends on the input mode. In the RGB-style modes they are the three colour components. In YC mode they are luma and the two chroma components. In colour-index mode every channel carries the same index.

Each comparator has its own enable. The results of the enabled comparators are combined with AND, and a master enable gates the outcome into a data key. The data key is then combined with OR with the external hardware key, which counts only while its own enable input is high. The key request is registered once, so it comes out one clock after the pixel values that produced it. It has the same latency as a registered hardware key.

Software loads the key values and the control bits through a simple write port with an address, data and a strobe. Every register clears on reset.

Top module: `ckey_match_gen`

## Requirements
- R1: While reset is low, key_out is 0. Reset clears the control bits and all three key values to 0, so after reset no data key is produced until software programs one.
- R2: A write at address 0 loads the control bits. Writes at addresses 5, 6 and 7 load the key values of channels D, E and F. A write to any other address changes no key value and no control bit.
- R3: Each comparator checks its channel's table input against its key value for exact equality over all 8 bits. The enables sit in control bit 3 for channel D, bit 2 for channel E and bit 1 for channel F.
- R4: When more than one comparator is enabled, the data key is raised only if every enabled comparator matches. If two enabled key values differ and the same index is applied to both channels, no data key results.
- R5: When control bit 4 (data key enable) is 0, the comparators produce no key, whatever they match.
- R6: When control bit 4 is 1 but bits 3 to 1 are all 0, no data key is produced.
- R7: The final key is the OR of the data key with (hw_key AND hw_key_en). hw_key has no effect while hw_key_en is 0.
- R8: key_out changes at the first rising clock edge after the pixel values and the hardware key are applied, and not before that edge.
- R9: In colour-index mode, with the same index on all three channels, enabling any single comparator is enough to detect the key index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 5/6/7 key values D/E/F |
| reg_wdata | input | 8 | Register write data |
| tbl_d | input | 8 | Table D input value for this pixel |
| tbl_e | input | 8 | Table E input value for this pixel |
| tbl_f | input | 8 | Table F input value for this pixel |
| hw_key | input | 1 | External hardware key for this pixel |
| hw_key_en | input | 1 | Enable for the external hardware key |
| key_out | output | 1 | Registered key request to the video switch |

## Verification
The assertions assume that the table inputs, the hardware key and its enable are known values on every clock edge after reset. They also assume that a register write takes effect only on later pixels, so the key computed in the same cycle as a write still uses the old settings. The stimulus holds every input at a defined value from time zero. It changes inputs only on falling edges. It places register writes between pixel runs, so that every scored pixel meets settled registers. Expected keys come from a separate model of the control bits and key values, which the bench updates whenever it issues a write.

// File: rtl/ckey_pkg.sv
`timescale 1ns/1ps
package ckey_pkg;

    localparam int unsigned NUM_CH        = 3;
    localparam int unsigned CTRL_ADDR     = 0;
    localparam int unsigned KEY_BASE_ADDR = 5;
    localparam int unsigned DATA_EN_BIT   = 4;
    localparam int unsigned CH_EN_TOP_BIT = 3;

    // ch_en[0] is channel D, ch_en[1] channel E, ch_en[2] channel F
    typedef struct packed {
        logic              data_en;
        logic [NUM_CH-1:0] ch_en;
    } ckey_ctrl_t;

endpackage

// File: rtl/ckey_regs.sv
`timescale 1ns/1ps
module ckey_regs
    import ckey_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output ckey_ctrl_t                    ctrl,
    output logic [NUM_CH-1:0][DATA_W-1:0] key_vals
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic ctrl_sel;
    assign ctrl_sel = wr_en && (wr_addr == CTRL_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (ctrl_sel) begin
            ctrl.data_en <= wr_data[DATA_EN_BIT];
            for (int c = 0; c < NUM_CH; c++) begin
                ctrl.ch_en[c] <= wr_data[CH_EN_TOP_BIT - c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_key
        localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_BASE_ADDR + c);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                key_vals[c] <= '0;
            end else if (wr_en && (wr_addr == KEY_A)) begin
                key_vals[c] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ckey_cmp.sv
`timescale 1ns/1ps
module ckey_cmp #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] pix,
    input  logic [DATA_W-1:0] key,
    output logic              vote,
    output logic              active
);

    // A disabled slice votes 1 so it is neutral in the AND reduction
    always_comb begin
        active = en;
        vote   = en ? (pix == key) : 1'b1;
    end

endmodule

// File: rtl/ckey_merge.sv
`timescale 1ns/1ps
module ckey_merge
    import ckey_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_en,
    input  logic [NUM_CH-1:0] votes,
    input  logic [NUM_CH-1:0] actives,
    input  logic              hw_key,
    input  logic              hw_key_en,
    output logic              key_q
);

    logic data_key;
    logic key_d;

    always_comb begin
        data_key = data_en && (|actives) && (&votes);
        key_d    = data_key || (hw_key && hw_key_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= 1'b0;
        end else begin
            key_q <= key_d;
        end
    end

endmodule

// File: rtl/ckey_match_gen.sv
`timescale 1ns/1ps
module ckey_match_gen
    import ckey_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] tbl_d,
    input  logic [DATA_W-1:0] tbl_e,
    input  logic [DATA_W-1:0] tbl_f,
    input  logic              hw_key,
    input  logic              hw_key_en,
    output logic              key_out
);

    ckey_ctrl_t                    ctrl_q;
    logic [NUM_CH-1:0][DATA_W-1:0] key_vals_q;
    logic [NUM_CH-1:0][DATA_W-1:0] pix_vec;
    logic [NUM_CH-1:0]             votes;
    logic [NUM_CH-1:0]             actives;

    assign pix_vec = {tbl_f, tbl_e, tbl_d};

    ckey_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .ctrl     (ctrl_q),
        .key_vals (key_vals_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        ckey_cmp #(
            .DATA_W (DATA_W)
        ) u_cmp (
            .en     (ctrl_q.ch_en[c]),
            .pix    (pix_vec[c]),
            .key    (key_vals_q[c]),
            .vote   (votes[c]),
            .active (actives[c])
        );
    end

    ckey_merge u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_en   (ctrl_q.data_en),
        .votes     (votes),
        .actives   (actives),
        .hw_key    (hw_key),
        .hw_key_en (hw_key_en),
        .key_q     (key_out)
    );

endmodule

// File: rtl/ckey_match_gen_chk.sv
`timescale 1ns/1ps
module ckey_match_gen_chk
    import ckey_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [DATA_W-1:0]             reg_wdata,
    input logic [DATA_W-1:0]             tbl_d,
    input logic [DATA_W-1:0]             tbl_e,
    input logic [DATA_W-1:0]             tbl_f,
    input logic                          hw_key,
    input logic                          hw_key_en,
    input logic                          key_out,
    input ckey_ctrl_t                    ctrl_q,
    input logic [NUM_CH-1:0][DATA_W-1:0] key_vals_q
);

    logic hw_on;
    logic miss_any;
    logic key_wr;

    assign hw_on    = hw_key && hw_key_en;
    assign miss_any = (ctrl_q.ch_en[0] && (tbl_d != key_vals_q[0])) ||
                      (ctrl_q.ch_en[1] && (tbl_e != key_vals_q[1])) ||
                      (ctrl_q.ch_en[2] && (tbl_f != key_vals_q[2]));
    assign key_wr   = reg_wr && (reg_addr >= ADDR_W'(KEY_BASE_ADDR));

    // R1: output held low throughout reset
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_low_r1: assert (!key_out);
        end
    end

    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(CTRL_ADDR)) |=>
            (ctrl_q.data_en == $past(reg_wdata[DATA_EN_BIT])));

    p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> $stable(key_vals_q));

    p_cmp_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_on && miss_any) |=> !key_out);

    p_all_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.data_en && (ctrl_q.ch_en != '0) && !miss_any) |=> key_out);

    p_data_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_on && !ctrl_q.data_en) |=> !key_out);

    p_no_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_on && ctrl_q.ch_en == '0) |=> !key_out);

    p_hw_key_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_on |=> key_out);

endmodule

bind ckey_match_gen ckey_match_gen_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .tbl_d      (tbl_d),
    .tbl_e      (tbl_e),
    .tbl_f      (tbl_f),
    .hw_key     (hw_key),
    .hw_key_en  (hw_key_en),
    .key_out    (key_out),
    .ctrl_q     (ctrl_q),
    .key_vals_q (key_vals_q)
);

// File: tb/ckey_match_gen_bench.sv
`timescale 1ns/1ps
module ckey_match_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] tbl_d = '0;
    logic [7:0] tbl_e = '0;
    logic [7:0] tbl_f = '0;
    logic       hw_key = 1'b0;
    logic       hw_key_en = 1'b0;
    logic       key_out;

    always #2 clk = ~clk;

    ckey_match_gen u_ckey_match_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .tbl_d     (tbl_d),
        .tbl_e     (tbl_e),
        .tbl_f     (tbl_f),
        .hw_key    (hw_key),
        .hw_key_en (hw_key_en),
        .key_out   (key_out)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t sb_q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    // Bench model of the programmed state
    logic [7:0] m_key [3];
    logic       m_en  [3];
    logic       m_den;

    function automatic logic model(input logic [7:0] d, input logic [7:0] e,
                                   input logic [7:0] f, input logic hk, input logic hen);
        logic [7:0] px [3];
        logic any_en;
        logic all_hit;
        px[0] = d; px[1] = e; px[2] = f;
        any_en = 1'b0;
        all_hit = 1'b1;
        for (int i = 0; i < 3; i++) begin
            if (m_en[i]) begin
                any_en = 1'b1;
                if (px[i] != m_key[i]) all_hit = 1'b0;
            end
        end
        return (m_den && any_en && all_hit) || (hk && hen);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: key_out=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 3'd0) begin
            m_den = v[4]; m_en[0] = v[3]; m_en[1] = v[2]; m_en[2] = v[1];
        end else if (a >= 3'd5) begin
            m_key[a - 3'd5] = v;
        end
    endtask

    task automatic pix(input logic [7:0] d, input logic [7:0] e, input logic [7:0] f,
                       input logic hk, input logic hen, input string tag);
        item_t it;
        @(negedge clk);
        tbl_d = d; tbl_e = e; tbl_f = f; hw_key = hk; hw_key_en = hen;
        it.exp = model(d, e, f, hk, hen);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: result of a pixel applied at a falling edge appears after the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(key_out, it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_key[i] = '0; m_en[i] = 1'b0; end
        m_den = 1'b0;

        // R1: hardware key asserted during reset must not reach the output
        hw_key = 1'b1; hw_key_en = 1'b1;
        #3 check(key_out, 1'b0, "R1 low at start of reset");
        repeat (3) @(posedge clk);
        #1 check(key_out, 1'b0, "R1 low while reset held");
        @(negedge clk);
        hw_key = 1'b0; hw_key_en = 1'b0;
        rst_n = 1'b1;

        // R1: cleared registers, zero tables equal zero keys, but nothing enabled
        pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R1 cleared control gives no key");

        reg_write(3'd5, 8'h12);
        reg_write(3'd6, 8'h34);
        reg_write(3'd7, 8'h56);

        // R3: channel D only (bits 4 and 3)
        reg_write(3'd0, 8'h18);
        pix(8'h12, 8'h00, 8'h00, 1'b0, 1'b0, "R3 D exact match");
        pix(8'h13, 8'h34, 8'h56, 1'b0, 1'b0, "R3 D lsb differs");
        pix(8'h92, 8'h34, 8'h56, 1'b0, 1'b0, "R3 D msb differs");
        // R3: channel E only (bits 4 and 2)
        reg_write(3'd0, 8'h14);
        pix(8'h00, 8'h34, 8'h00, 1'b0, 1'b0, "R3 E match");
        pix(8'h12, 8'h35, 8'h56, 1'b0, 1'b0, "R3 E miss");
        // R3: channel F only (bits 4 and 1)
        reg_write(3'd0, 8'h12);
        pix(8'h00, 8'h00, 8'h56, 1'b0, 1'b0, "R3 F match");
        pix(8'h12, 8'h34, 8'h57, 1'b0, 1'b0, "R3 F miss");

        // R4: all three comparators enabled
        reg_write(3'd0, 8'h1E);
        pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, "R4 all enabled all match");
        pix(8'h12, 8'h34, 8'h57, 1'b0, 1'b0, "R4 one of three misses");
        pix(8'h11, 8'h34, 8'h56, 1'b0, 1'b0, "R4 first misses");

        // R8: alternating stream checks per-pixel alignment
        pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, "R8 stream hit");
        pix(8'h00, 8'h34, 8'h56, 1'b0, 1'b0, "R8 stream miss");
        #1 check(key_out, 1'b1, "R8 output unchanged before edge");
        pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, "R8 stream hit again");
        #1 check(key_out, 1'b0, "R8 output unchanged before edge");
        pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, "R8 stream hit held");

        // R5: data key enable cleared, comparators still enabled
        reg_write(3'd0, 8'h0E);
        pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, "R5 data keying off");
        pix(8'h12, 8'h34, 8'h56, 1'b1, 1'b1, "R7 hw key with data off");

        // R6: data key enabled with no comparator
        reg_write(3'd0, 8'h10);
        pix(8'h12, 8'h34, 8'h56, 1'b0, 1'b0, "R6 no comparator enabled");
        pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R6 no comparator zeros");

        // R7: hardware key merge
        reg_write(3'd0, 8'h18);
        pix(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R7 hw key ignored without enable");
        pix(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R7 hw key alone");
        pix(8'h12, 8'h00, 8'h00, 1'b1, 1'b1, "R7 hw and data together");
        pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R7 enable without hw key");
        pix(8'h12, 8'h00, 8'h00, 1'b0, 1'b0, "R7 data key alone");

        // R2: writes to unused addresses leave keys and control untouched
        reg_write(3'd3, 8'h00);
        reg_write(3'd1, 8'h00);
        reg_write(3'd4, 8'hFF);
        pix(8'h12, 8'h00, 8'h00, 1'b0, 1'b0, "R2 unused address writes ignored");
        pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2 control kept after ignored write");

        // R9: colour index, only F enabled
        reg_write(3'd7, 8'h40);
        reg_write(3'd0, 8'h12);
        pix(8'h40, 8'h40, 8'h40, 1'b0, 1'b0, "R9 index match via F");
        pix(8'h41, 8'h41, 8'h41, 1'b0, 1'b0, "R9 index miss");

        // R4: two enabled comparators with different key values never key
        reg_write(3'd5, 8'h40);
        reg_write(3'd6, 8'h41);
        reg_write(3'd0, 8'h1C);
        pix(8'h40, 8'h40, 8'h40, 1'b0, 1'b0, "R4 conflicting keys index 40");
        pix(8'h41, 8'h41, 8'h41, 1'b0, 1'b0, "R4 conflicting keys index 41");

        // R9: D and E with equal keys detect the index
        reg_write(3'd6, 8'h40);
        pix(8'h40, 8'h40, 8'h40, 1'b0, 1'b0, "R9 index match via D and E");

        pix(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R3 final miss");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule